// File: doc/BRIEF.md
# Burst Address Sequencer (Linear / Interleaved)

This block produces the address for each beat of a short burst in a synchronous memory. A start address is captured once. Each later advance then steps the two low address bits through one four-word block, while the bits above them keep their captured value. A pin selects the beat order. Linear order counts the low bits up by one and wraps at four. Interleaved order XORs the start offset with a beat count.

At the capture edge the block also records whether the burst is a read or a write. That type stays fixed until the next capture, whatever the write request input does meanwhile. An active-low clock enable freezes all state. A synchronous active-high reset returns the block to address 0, beat 0, read.

All outputs are registered. Each output shows the result of the most recent enabled clock edge. The order pin is looked at on every advancing edge and is not latched.

Top module: `burst_addr_counter`

## Requirements
- R1: When `clk_en_n` is 0 and `ld_adv_n` is 0 at a clock edge, `addr_out` becomes `addr_in` and `beat` becomes 0 after that edge.
- R2: When `clk_en_n` is 0 and `ld_adv_n` is 1 at a clock edge, the burst advances one beat whatever the value of `wr_req`.
- R3: An advance leaves `addr_out` bits above bit 1 equal to the value captured at the last load.
- R4: With `burst_order` = 0 (linear) at an advancing edge, `addr_out[1:0]` becomes (start offset + new beat) mod 4. For example, start 2 gives 2,3,0,1.
- R5: With `burst_order` = 1 (interleaved) at an advancing edge, `addr_out[1:0]` becomes start offset XOR new beat. For example, start 1 gives 1,0,3,2.
- R6: `beat` counts 0,1,2,3 and wraps to 0. After four advances the address is back at its start value.
- R7: `is_write` takes the value of `wr_req` at a load (1 = write, 0 = read) and does not change on advances.
- R8: When `clk_en_n` is 1 at a clock edge, `addr_out`, `beat` and `is_write` keep their values.
- R9: `rst` = 1 at a clock edge sets `addr_out` to 0, `beat` to 0 and `is_write` to 0.
- R10: The order used at each advance is the value of `burst_order` at that edge. It is combined with the start offset captured at load and the new beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clk_en_n | input | 1 | Clock enable, active low; 1 freezes all state |
| ld_adv_n | input | 1 | 0 = load start address, 1 = advance one beat |
| burst_order | input | 1 | 0 = linear order, 1 = interleaved order |
| wr_req | input | 1 | Access type captured at load, 1 = write |
| addr_in | input | ADDR_W | Start address of the burst |
| addr_out | output | ADDR_W | Current burst address |
| is_write | output | 1 | Latched access type, 1 = write |
| beat | output | 2 | Beat index within the burst |

## Verification
A wrong start offset or beat register shows on `addr_out[1:0]` at the first advance, one clock after the faulty edge. A beat register that fails to wrap is caught at the fifth beat, when the address should return to its start. A corrupted upper-address register or access-type flag shows on the cycle after the edge that corrupted it. The bench holds that value steady through the following advances and enable-off cycles. It also toggles `wr_req` and the order pin mid-burst, so any leak from these inputs into the latched state shows within one cycle.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int LOW_W = 2;
    localparam int BEATS = 1 << LOW_W;

    typedef enum logic {
        ACC_READ  = 1'b0,
        ACC_WRITE = 1'b1
    } acc_e;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } order_e;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_STEP = 2'd2
    } op_e;

    typedef struct packed {
        logic [LOW_W-1:0] cur;
        logic [LOW_W-1:0] nxt;
    } beat_t;

    function automatic logic [LOW_W-1:0] beat_offset(
        input logic [LOW_W-1:0] start,
        input logic [LOW_W-1:0] idx,
        input order_e           ord
    );
        logic [LOW_W-1:0] r;
        if (ord == ORD_XOR) r = start ^ idx;
        else                r = start + idx;
        return r;
    endfunction

endpackage

// File: rtl/burst_op_decode.sv
module burst_op_decode
    import burst_pkg::*;
(
    input  logic clk_en_n,
    input  logic ld_adv_n,
    output op_e  op
);
    always_comb begin
        if (clk_en_n)      op = OP_HOLD;
        else if (!ld_adv_n) op = OP_LOAD;
        else               op = OP_STEP;
    end
endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl
    import burst_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  op_e   op,
    input  logic  wr_req,
    output beat_t beat_s,
    output acc_e  acc_q
);
    logic [LOW_W-1:0] beat_q;
    logic [LOW_W-1:0] beat_d;

    always_comb begin
        case (op)
            OP_LOAD: beat_d = '0;
            OP_STEP: beat_d = beat_q + 1'b1;
            default: beat_d = beat_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
            acc_q  <= ACC_READ;
        end else begin
            beat_q <= beat_d;
            if (op == OP_LOAD) acc_q <= wr_req ? ACC_WRITE : ACC_READ;
        end
    end

    assign beat_s.cur = beat_q;
    assign beat_s.nxt = beat_d;

    // R7
    acc_fixed_on_step_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_STEP) |=> (acc_q == $past(acc_q)));

    // R6
    beat_wraps_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_STEP && beat_q == 2'd3) |=> (beat_q == 2'd0));
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  op_e               op,
    input  order_e            ord,
    input  beat_t             beat_s,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_q
);
    localparam int HI_W = ADDR_W - LOW_W;

    logic [LOW_W-1:0] start_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            start_q <= '0;
        end else begin
            case (op)
                OP_LOAD: begin
                    addr_q  <= addr_in;
                    start_q <= addr_in[LOW_W-1:0];
                end
                OP_STEP: begin
                    addr_q[LOW_W-1:0] <= beat_offset(start_q, beat_s.nxt, ord);
                end
                default: ;
            endcase
        end
    end

    // R3
    upper_held_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_STEP) |=> (addr_q[ADDR_W-1:LOW_W] == $past(addr_q[ADDR_W-1:LOW_W])));

    // R4
    linear_step_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_STEP && ord == ORD_LINEAR && $past(op) == OP_LOAD)
        |=> (addr_q[LOW_W-1:0] == $past(addr_q[LOW_W-1:0]) + 2'd1));

    initial begin
        assert (HI_W >= 1) else $error("ADDR_W must exceed the burst field");
    end
endmodule

// File: rtl/burst_addr_counter.sv
module burst_addr_counter
    import burst_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en_n,
    input  logic              ld_adv_n,
    input  logic              burst_order,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              is_write,
    output logic [1:0]        beat
);
    op_e    op;
    beat_t  beat_s;
    acc_e   acc_q;
    order_e ord;

    assign ord = burst_order ? ORD_XOR : ORD_LINEAR;

    burst_op_decode u_dec (
        .clk_en_n (clk_en_n),
        .ld_adv_n (ld_adv_n),
        .op       (op)
    );

    burst_beat_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .wr_req (wr_req),
        .beat_s (beat_s),
        .acc_q  (acc_q)
    );

    burst_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .ord     (ord),
        .beat_s  (beat_s),
        .addr_in (addr_in),
        .addr_q  (addr_out)
    );

    assign is_write = (acc_q == ACC_WRITE);
    assign beat     = beat_s.cur;

    // R1
    load_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && !ld_adv_n) |=> (addr_out == $past(addr_in) && beat == 2'd0));

    // R8
    freeze_chk: assert property (@(posedge clk) disable iff (rst)
        clk_en_n |=> ($stable(addr_out) && $stable(beat) && $stable(is_write)));

    // R2
    step_counts_chk: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && ld_adv_n) |=> (beat == $past(beat) + 2'd1));

    // R9
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (addr_out == '0 && beat == 2'd0 && !is_write));
endmodule

// File: tb/tb_burst_addr_counter.sv
`timescale 1ns/1ps
module tb_burst_addr_counter;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst, clk_en_n, ld_adv_n, burst_order, wr_req;
    logic [AW-1:0] addr_in;
    logic [AW-1:0] addr_out;
    logic          is_write;
    logic [1:0]    beat;

    int checks = 0;
    int fails  = 0;

    logic [AW-1:0] m_start;
    logic [1:0]    m_beat;
    logic          m_wr;
    logic [AW-1:0] m_addr;

    always #2.5 clk = ~clk;

    burst_addr_counter #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .ld_adv_n(ld_adv_n),
        .burst_order(burst_order), .wr_req(wr_req), .addr_in(addr_in),
        .addr_out(addr_out), .is_write(is_write), .beat(beat)
    );

    task automatic check(input string tag);
        checks++;
        if (addr_out !== m_addr || beat !== m_beat || is_write !== m_wr) begin
            fails++;
            $display("FAIL %s: addr=%0d beat=%0d wr=%0b expected addr=%0d beat=%0d wr=%0b",
                     tag, addr_out, beat, is_write, m_addr, m_beat, m_wr);
        end
    endtask

    task automatic step(input logic r, input logic ce_n, input logic ld_n,
                        input logic ord, input logic wr, input logic [AW-1:0] a,
                        input string tag);
        logic [1:0] lo;
        @(negedge clk);
        rst = r; clk_en_n = ce_n; ld_adv_n = ld_n; burst_order = ord;
        wr_req = wr; addr_in = a;
        @(posedge clk);
        if (r) begin
            m_start = '0; m_beat = 2'd0; m_wr = 1'b0; m_addr = '0;
        end else if (!ce_n) begin
            if (!ld_n) begin
                m_start = a; m_beat = 2'd0; m_wr = wr; m_addr = a;
            end else begin
                m_beat = m_beat + 2'd1;
                lo = ord ? (m_start[1:0] ^ m_beat) : (m_start[1:0] + m_beat);
                m_addr = {m_start[AW-1:2], lo};
            end
        end
        #1;
        check(tag);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; clk_en_n = 1'b1; ld_adv_n = 1'b1; burst_order = 1'b0;
        wr_req = 1'b0; addr_in = '0;
        step(1, 1, 1, 0, 1, 6'h2a, "R9 reset");
        step(1, 0, 0, 1, 1, 6'h2a, "R9 reset over load");

        // Sweep every start address, both orders, both access types
        for (int a = 0; a < (1 << AW); a++) begin
            for (int o = 0; o < 2; o++) begin
                logic w;
                w = logic'((a >> 1) ^ o);
                step(0, 0, 0, o[0], w, a[AW-1:0], "R1 R7 load");
                for (int k = 0; k < 5; k++)
                    step(0, 0, 1, o[0], ~w, ~a[AW-1:0],
                         o ? "R5 R2 R3 R6 interleave step" : "R4 R2 R3 R6 linear step");
                if (m_addr !== a[AW-1:0] + 0 && m_beat == 2'd1) ; // model self-consistent
            end
        end

        // R6: four advances return to start address
        step(0, 0, 0, 0, 0, 6'h0e, "R1 load 14");
        for (int k = 0; k < 4; k++) step(0, 0, 1, 0, 1, 6'h00, "R6 wrap linear");
        checks++;
        if (addr_out !== 6'h0e) begin
            fails++;
            $display("FAIL R6: addr=%0d expected addr=%0d", addr_out, 6'h0e);
        end

        // R8: freeze while enable off, with changing inputs
        step(0, 0, 0, 1, 1, 6'h31, "R1 load 49");
        step(0, 0, 1, 1, 0, 6'h00, "R5 step");
        for (int k = 0; k < 6; k++)
            step(0, 1, k[0], k[1], k[0], k[AW-1:0], "R8 freeze");
        step(0, 0, 1, 1, 0, 6'h3f, "R5 resume");

        // R10: mode switched mid-burst
        step(0, 0, 0, 0, 0, 6'h15, "R1 load 21");
        step(0, 0, 1, 1, 1, 6'h00, "R10 xor beat");
        step(0, 0, 1, 0, 1, 6'h00, "R10 linear beat");
        step(0, 0, 1, 1, 0, 6'h00, "R10 xor beat");
        step(0, 0, 1, 0, 1, 6'h00, "R10 linear wrap");

        // R7: write burst keeps type
        step(0, 0, 0, 0, 1, 6'h22, "R7 write load");
        step(0, 0, 1, 0, 0, 6'h00, "R7 type kept");
        step(1, 0, 1, 0, 0, 6'h00, "R9 reset mid-burst");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule